// File: doc/BRIEF.md
# Threshold Trigger with Rolling Pre-Event History

This block sits between a channel selector and a sample packetizer and decides when captured samples start flowing out. Four channels of sample data arrive on a strobe. Channel 0 is always the trigger source. It is compared as an unsigned number against a programmed threshold under one of three conditions. The block then gates the stream to its output.

In post-trigger mode nothing leaves the block until a sample meets the condition. That sample and every later one are then emitted. In pre-trigger mode every sample is also written into a 100-entry circular history memory. A read pointer trails the write pointer by the number of entries held. Before the event it only moves once the memory is full. From the event onward it moves on every strobe, so the samples from before the event come out first, in order, followed by the live samples at a fixed delay. With the trigger disabled, the block passes every sample as soon as a run starts.

The state machine has five states:
- `S_IDLE`: not running.
- `S_WAIT`: armed, post mode.
- `S_PASS`: streaming live samples.
- `S_HIST`: armed, recording history.
- `S_REPLAY`: streaming through the history memory.

The transitions are:
- `S_IDLE` to `S_PASS` on `run` high with the trigger disabled.
- `S_IDLE` to `S_WAIT` on `run` high, trigger enabled, post mode.
- `S_IDLE` to `S_HIST` on `run` high, trigger enabled, pre mode.
- `S_WAIT` to `S_PASS` on a strobe that matches.
- `S_HIST` to `S_REPLAY` on a strobe that matches.
- Any state to `S_IDLE` whenever `run` is low.

`trig_en` and `trig_mode` are taken at the `S_IDLE` exit. Condition and threshold are used live.

Top module: `trig_capture`

## Requirements
- R1: After reset `out_valid` is 0. While `run` is low no strobe produces an output.
- R2: Condition code 0 (above) fires when channel 0, bits [31:0] of `ch_data`, is greater than `trig_value` as an unsigned number.
- R3: Condition code 1 (below) fires when channel 0 is less than `trig_value`, unsigned.
- R4: Condition code 2 (equal) fires on equality. Code 3 never fires.
- R5: Only channel 0 is compared. A match on channels 1 to 3 (bits [127:32]) does not fire.
- R6: In post mode (`trig_mode`=0) the first sample output is the first matching sample. It appears with `out_valid` high in the cycle after its strobe, with `out_data` equal to the full 128-bit sample.
- R7: Once fired, the trigger stays fired for the rest of the run. Every later strobe is output, whether it matches or not.
- R8: With `trig_en`=0 every strobe after start is output in the following cycle, in either mode.
- R9: In pre mode (`trig_mode`=1) nothing is output before the event. With the history full (at least 100 earlier samples), the first output at the event is the sample taken 100 strobes before the event. Later outputs follow in order at that same delay.
- R10: In pre mode with fewer than 100 earlier samples, the output starts with the first sample of the run. It continues in order at a delay equal to the number of samples held at the event.
- R11: In pre mode, an event on the first strobe of a run outputs that strobe's own sample and then the live samples.
- R12: Dropping `run` returns the block to idle and empties the history. A new run never emits samples from an earlier run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High to capture; rising edge starts a run, low stops and clears |
| sample_stb | input | 1 | One-cycle strobe marking a new sample on `ch_data` |
| ch_data | input | 128 | Four 32-bit channels, channel 0 in bits [31:0] |
| trig_value | input | 32 | Threshold compared with channel 0 |
| trig_cond | input | 2 | 0 above, 1 below, 2 equal, 3 never |
| trig_mode | input | 1 | 0 post-trigger, 1 pre-trigger history |
| trig_en | input | 1 | 1 gates output on the trigger, 0 passes all samples |
| out_valid | output | 1 | High for one cycle per emitted sample |
| out_data | output | 128 | Emitted sample |

## Verification
The hardest situation to reach is a full history memory at the moment of the event. In that case the read and write addresses coincide, and the output comes from the read-first behaviour of the memory, not from a bypass. The stimulus reaches it by feeding 150 distinct samples before a matching one, so the write pointer has wrapped at least once. It then checks that the output is the sample from exactly 100 strobes earlier. Two short runs cover the edges of the trailing gap: one with five held samples, and one that fires on the first strobe. A restart on top of the stale full memory shows that old entries never leak into a new run.

// File: rtl/trig_pkg.sv
package trig_pkg;
    typedef enum logic [1:0] {
        C_ABOVE = 2'd0,
        C_BELOW = 2'd1,
        C_EQUAL = 2'd2,
        C_NEVER = 2'd3
    } trig_cond_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_PASS,
        S_HIST,
        S_REPLAY
    } cap_state_t;
endpackage

// File: rtl/trig_cmp.sv
module trig_cmp
    import trig_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] sample,
    input  logic [W-1:0] thresh,
    input  logic [1:0]   cond,
    output logic         hit
);
    trig_cond_t c;
    always_comb begin
        c = trig_cond_t'(cond);
        unique case (c)
            C_ABOVE: hit = (sample > thresh);
            C_BELOW: hit = (sample < thresh);
            C_EQUAL: hit = (sample == thresh);
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/hist_ram.sv
module hist_ram #(
    parameter int W     = 128,
    parameter int DEPTH = 100,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic          re,
    input  logic [AW-1:0] ra,
    output logic [W-1:0]  rq
);
    logic [W-1:0] mem [DEPTH];

    // read-first: a read at the address being written returns the old entry
    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
        if (re) rq <= mem[ra];
    end
endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
    import trig_pkg::*;
#(
    parameter int DEPTH = 100,
    parameter int AW    = $clog2(DEPTH),
    parameter int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            stb,
    input  logic            hit,
    input  logic            trig_en,
    input  logic            pre_mode,
    output logic            we,
    output logic [AW-1:0]   wa,
    output logic [AW-1:0]   ra,
    output logic            emit_q,
    output logic            from_ram_q,
    output cap_state_t      state,
    output logic [CNTW-1:0] cnt
);
    localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);
    localparam logic [AW-1:0]   LAST = AW'(DEPTH - 1);

    cap_state_t nxt;
    logic emit, from_ram, adv_rd, grow;
    logic [AW-1:0] wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt      = state;
        we       = 1'b0;
        emit     = 1'b0;
        from_ram = 1'b0;
        adv_rd   = 1'b0;
        grow     = 1'b0;
        if (!run) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  nxt = !trig_en ? S_PASS : (pre_mode ? S_HIST : S_WAIT);
                S_WAIT:  if (stb && hit) begin
                             emit = 1'b1;
                             nxt  = S_PASS;
                         end
                S_PASS:  emit = stb;
                S_HIST:  if (stb) begin
                             we = 1'b1;
                             if (hit) begin
                                 emit     = 1'b1;
                                 from_ram = (cnt != '0);
                                 adv_rd   = 1'b1;
                                 nxt      = S_REPLAY;
                             end else if (cnt == FULL) begin
                                 adv_rd = 1'b1;
                             end else begin
                                 grow = 1'b1;
                             end
                         end
                S_REPLAY: if (stb) begin
                             we       = 1'b1;
                             emit     = 1'b1;
                             from_ram = (cnt != '0);
                             adv_rd   = 1'b1;
                         end
                default: nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (we)     wr_ptr <= step(wr_ptr);
            if (adv_rd) rd_ptr <= step(rd_ptr);
            if (grow)   cnt    <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emit_q     <= 1'b0;
            from_ram_q <= 1'b0;
        end else begin
            emit_q     <= emit;
            from_ram_q <= from_ram;
        end
    end

    assign wa = wr_ptr;
    assign ra = rd_ptr;
endmodule

// File: rtl/trig_capture.sv
module trig_capture
    import trig_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int CH_W  = 32,
    parameter int DEPTH = 100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 sample_stb,
    input  logic [N_CH*CH_W-1:0] ch_data,
    input  logic [CH_W-1:0]      trig_value,
    input  logic [1:0]           trig_cond,
    input  logic                 trig_mode,
    input  logic                 trig_en,
    output logic                 out_valid,
    output logic [N_CH*CH_W-1:0] out_data
);
    localparam int DW   = N_CH * CH_W;
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic            hit, we, from_ram_q;
    logic [AW-1:0]   wa, ra;
    logic [DW-1:0]   ram_q, live_q;
    logic [CNTW-1:0] hist_cnt;
    cap_state_t      st;

    trig_cmp #(.W(CH_W)) u_cmp (
        .sample (ch_data[CH_W-1:0]),
        .thresh (trig_value),
        .cond   (trig_cond),
        .hit    (hit)
    );

    trig_ctrl #(.DEPTH(DEPTH), .AW(AW), .CNTW(CNTW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .stb        (sample_stb),
        .hit        (hit),
        .trig_en    (trig_en),
        .pre_mode   (trig_mode),
        .we         (we),
        .wa         (wa),
        .ra         (ra),
        .emit_q     (out_valid),
        .from_ram_q (from_ram_q),
        .state      (st),
        .cnt        (hist_cnt)
    );

    hist_ram #(.W(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk (clk),
        .we  (we),
        .wa  (wa),
        .wd  (ch_data),
        .re  (we),
        .ra  (ra),
        .rq  (ram_q)
    );

    always_ff @(posedge clk) begin
        if (sample_stb) live_q <= ch_data;
    end

    assign out_data = from_ram_q ? ram_q : live_q;
endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk
    import trig_pkg::*;
#(
    parameter int DEPTH = 100,
    parameter int AW    = $clog2(DEPTH),
    parameter int CNTW  = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run,
    input logic            sample_stb,
    input logic            out_valid,
    input cap_state_t      st,
    input logic [CNTW-1:0] cnt,
    input logic [AW-1:0]   wa,
    input logic [AW-1:0]   ra
);
    // R6: an output only follows a strobe
    a_r6_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(sample_stb));

    // R1, R12: no output in the cycle after run was low
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> !out_valid);

    // R10: the trailing gap never exceeds the history depth
    a_r10_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNTW'(DEPTH));

    // R9: with a full history, read and write addresses coincide
    a_r9_full_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNTW'(DEPTH)) |-> (ra == wa));

    // R9: the gap stays constant while replaying
    a_r9_gap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_REPLAY && $past(st) == S_REPLAY) |-> $stable(cnt));
endmodule

bind trig_capture trig_capture_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .sample_stb (sample_stb),
    .out_valid  (out_valid),
    .st         (st),
    .cnt        (hist_cnt),
    .wa         (wa),
    .ra         (ra)
);

// File: tb/trig_capture_bench.sv
module trig_capture_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run = 1'b0;
    logic         sample_stb = 1'b0;
    logic [127:0] ch_data = '0;
    logic [31:0]  trig_value = '0;
    logic [1:0]   trig_cond = '0;
    logic         trig_mode = 1'b0;
    logic         trig_en = 1'b0;
    logic         out_valid;
    logic [127:0] out_data;

    int checks = 0;
    int errors = 0;
    logic         got_v;
    logic [127:0] got_d;

    always #2.5 clk = ~clk;

    trig_capture u_trig_capture (
        .clk(clk), .rst_n(rst_n), .run(run), .sample_stb(sample_stb),
        .ch_data(ch_data), .trig_value(trig_value), .trig_cond(trig_cond),
        .trig_mode(trig_mode), .trig_en(trig_en),
        .out_valid(out_valid), .out_data(out_data)
    );

    typedef struct packed {
        logic [1:0]  cond;
        logic [31:0] tval;
        logic [31:0] s0;
        logic        fire;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'd10,         32'd11,         1'b1},  // R2
        '{2'd0, 32'd10,         32'd10,         1'b0},  // R2
        '{2'd0, 32'd1,          32'h8000_0000,  1'b1},  // R2 unsigned
        '{2'd1, 32'd10,         32'd9,          1'b1},  // R3
        '{2'd1, 32'd10,         32'd10,         1'b0},  // R3
        '{2'd1, 32'd5,          32'hFFFF_FFFF,  1'b0},  // R3 unsigned
        '{2'd2, 32'hDEAD_BEEF,  32'hDEAD_BEEF,  1'b1},  // R4
        '{2'd2, 32'd5,          32'd6,          1'b0},  // R4
        '{2'd3, 32'd5,          32'd5,          1'b0}   // R4 never
    };

    function automatic logic [127:0] mk(input int base, input int k);
        logic [31:0] v;
        v = 32'(base + k);
        return {32'hC0DE_0000 ^ v, v << 4, ~v, v};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [127:0] d);
        @(negedge clk);
        ch_data = d;
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        got_v = out_valid;
        got_d = out_data;
    endtask

    task automatic start(input logic en, input logic mode,
                         input logic [1:0] cond, input logic [31:0] tv);
        @(negedge clk);
        trig_en = en;
        trig_mode = mode;
        trig_cond = cond;
        trig_value = tv;
        run = 1'b1;
        @(negedge clk);
    endtask

    task automatic stop();
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic [127:0] exp);
        check(got_v === 1'b1, tag, {127'd0, got_v}, 128'd1);
        if (got_v === 1'b1) check(got_d === exp, tag, got_d, exp);
    endtask

    task automatic expect_none(input string tag);
        check(got_v === 1'b0, tag, {127'd0, got_v}, 128'd0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int quiet;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1 reset", {127'd0, out_valid}, 128'd0);
        rst_n = 1'b1;
        pulse(mk(0, 1));
        expect_none("R1 idle strobe");

        // comparator table, post mode
        for (int i = 0; i < NV; i++) begin
            start(1'b1, 1'b0, VECS[i].cond, VECS[i].tval);
            pulse({96'h1234_5678_9ABC_DEF0_0F0F_0F0F, VECS[i].s0});
            check(got_v === VECS[i].fire,
                  VECS[i].cond == 2'd0 ? "R2 cond" :
                  VECS[i].cond == 2'd1 ? "R3 cond" : "R4 cond",
                  {127'd0, got_v}, {127'd0, VECS[i].fire});
            stop();
        end

        // R5: channels 1..3 matching must not fire
        start(1'b1, 1'b0, 2'd2, 32'd7);
        pulse({32'd7, 32'd7, 32'd7, 32'd3});
        expect_none("R5 other channel");
        pulse({32'd1, 32'd2, 32'd3, 32'd7});
        expect_out("R5 channel 0", {32'd1, 32'd2, 32'd3, 32'd7});
        stop();

        // R6, R7: post mode first match then latched
        start(1'b1, 1'b0, 2'd0, 32'd100);
        pulse(mk(50, 0));
        expect_none("R6 before match");
        pulse(mk(200, 0));
        expect_out("R6 first match", mk(200, 0));
        pulse(mk(20, 0));
        expect_out("R7 latched", mk(20, 0));
        pulse(mk(30, 0));
        expect_out("R7 latched", mk(30, 0));
        stop();

        // R8: trigger disabled passes everything
        start(1'b0, 1'b1, 2'd3, 32'd0);
        for (int k = 0; k < 4; k++) begin
            pulse(mk(500, k));
            expect_out("R8 pass", mk(500, k));
        end
        stop();

        // R9: full history, event after 150 samples
        start(1'b1, 1'b1, 2'd2, 32'd150);
        quiet = 0;
        for (int k = 0; k < 150; k++) begin
            pulse(mk(0, k));
            if (got_v) quiet++;
        end
        check(quiet == 0, "R9 quiet before event", 128'(quiet), 128'd0);
        for (int k = 150; k < 156; k++) begin
            pulse(mk(0, k));
            expect_out("R9 delayed history", mk(0, k - 100));
        end
        stop();
        pulse(mk(0, 7));
        expect_none("R12 stopped");

        // R12: restart over stale memory
        start(1'b1, 1'b1, 2'd2, 32'd3002);
        pulse(mk(3000, 0));
        expect_none("R12 restart quiet");
        pulse(mk(3000, 1));
        expect_none("R12 restart quiet");
        pulse(mk(3000, 2));
        expect_out("R12 fresh history", mk(3000, 0));
        pulse(mk(3000, 3));
        expect_out("R12 fresh history", mk(3000, 1));
        stop();

        // R10: partial history, event after 5 samples
        start(1'b1, 1'b1, 2'd2, 32'd1005);
        for (int k = 0; k < 5; k++) pulse(mk(1000, k));
        for (int k = 5; k < 10; k++) begin
            pulse(mk(1000, k));
            expect_out("R10 partial history", mk(1000, k - 5));
        end
        stop();

        // R11: event on the first strobe
        start(1'b1, 1'b1, 2'd2, 32'd2000);
        for (int k = 0; k < 3; k++) begin
            pulse(mk(2000, k));
            expect_out("R11 first strobe", mk(2000, k));
        end
        stop();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule